// File: doc/BRIEF.md
# Shared Cache Line State Controller

This block holds the coherence state of one line in a shared second-level cache. The cache sits between many first-level clients and a memory-side agent. Each cycle it may receive one event: a client read, write or atomic, a data fill or write-back acknowledgement from memory, an invalidating probe, or a replacement decision from the cache itself. The block registers the next line state. In the same cycle it raises single-cycle action strobes that tell the surrounding datapath what to do: reply to the client, issue a request to memory, write the line back, merge bytes, invalidate, or send the request back for a later retry.

A static mode input chooses how client writes are handled. In write-through mode a write that misses does not allocate and is forwarded to memory. In write-back mode every write is merged locally and acknowledged at once. The line has two dirty flavours. Modified means the line is dirty and fully owned. Written means the line is dirty but has already been probed. A probe demotes Modified to Written. Atomics are sent to memory, and a saturating counter tracks how many are still outstanding.

Top module: `l2_line_fsm`

## Requirements
- R1: After reset the line is Invalid and no atomics are pending. State codes are I=0, V=1, M=2, W=3, IV=4 (waiting for data), WI=5 (waiting for write-back ack) and A=6 (waiting on atomic data).
- R2: A read in M or V raises reply_data and touch, and the state is unchanged. A read in I raises trk_alloc and mem_read and moves to IV. A read in IV is absorbed with no strobe and no retry.
- R3: A read in W raises trk_alloc, mem_wback and retry, and moves to WI.
- R4: In write-through mode (wb_mode=0), a write in I raises only mem_wthru and stays in I. A write in V raises merge, touch and mem_wthru and stays in V. A write in M or W is illegal.
- R5: In write-back mode (wb_mode=1), a write in any stable state raises merge, touch and reply_ack. I goes to W, V and M go to M, and W stays in W.
- R6: Every probe raises probe_ack. I and V go to I, M goes to W, and W and the busy states are unchanged.
- R7: Reads, writes and atomics in WI, reads and writes in A, and writes and atomics in IV raise only retry, and the state is unchanged.
- R8: Data in IV raises fill, touch, reply_data, peer_done and trk_free, and moves to V.
- R9: An atomic in I or V raises inval, trk_alloc and mem_atomic, moves to A and sets the pending count to 1. An atomic in A raises mem_atomic and increments the count, or raises only retry if the count is at its maximum. An atomic in M or W raises trk_alloc, mem_wback and retry, and moves to WI.
- R10: Data in A raises reply_data and peer_done and decrements the count. On the last pending atomic it also raises trk_free and moves to I.
- R11: A write-back ack in WI raises peer_done and trk_free and moves to I. In I, V, IV or A it raises reply_ack and peer_done with no state change. In M or W it is illegal.
- R12: A replacement always raises inval. M and W also raise mem_wback and trk_alloc and move to WI. I and V go to I, and the busy states are unchanged.
- R13: Data in a stable state, a write-back ack in M or W, a write-through write in M or W, and the reserved event code 7 raise only ev_illegal, and the state is unchanged.
- R14: Event codes are RD=0, WR=1, ATOM=2, DATA=3, WBACK=4, PROBE=5, REPL=6. When ev_valid is low, no strobe is raised and the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wb_mode | input | 1 | 1 = write-back handling of client writes, 0 = write-through |
| ev_valid | input | 1 | Event present this cycle |
| ev_type | input | 3 | Event code |
| line_state | output | 3 | Current line state |
| atom_pend | output | CNT_W | Outstanding atomic count |
| reply_data | output | 1 | Send data to the client |
| reply_ack | output | 1 | Send a write acknowledgement to the client |
| mem_read | output | 1 | Issue a read request to memory |
| mem_atomic | output | 1 | Forward an atomic to memory |
| mem_wthru | output | 1 | Forward the client write to memory |
| mem_wback | output | 1 | Write the dirty line back to memory |
| merge | output | 1 | Merge the masked client bytes into the line |
| fill | output | 1 | Write memory data into the line |
| inval | output | 1 | Invalidate the line |
| probe_ack | output | 1 | Send a no-data, not-dirty, not-hit probe ack |
| peer_done | output | 1 | Send a completion to the region peer |
| retry | output | 1 | Request not consumed; retry later |
| touch | output | 1 | Mark the line most recently used |
| trk_alloc | output | 1 | Allocate a transaction tracker |
| trk_free | output | 1 | Free the transaction tracker |
| ev_illegal | output | 1 | No transition is defined for this event in this state |

## Verification
The bound checker watches several things on every cycle. A write-through write in I must leave the line in I. A retry without a write-back must leave the state and the count untouched. A probe in M must land in W. Any write-back or tracker allocation must end in a busy state. The pending count must be non-zero exactly while in A, and a data reply and a write ack must never be raised together. The exact set of strobes for each state and event pair can only be shown by the bench's scenarios. The same holds for the write-back versus write-through split, the behaviour of the counter at saturation, and the last-atomic release. The bench drives the line into each of the seven states, in both modes, and compares every event against an independent transition table.

// File: rtl/l2_line_fsm.sv
module l2_line_fsm #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_mode,
  input  logic             ev_valid,
  input  logic [2:0]       ev_type,
  output logic [2:0]       line_state,
  output logic [CNT_W-1:0] atom_pend,
  output logic             reply_data,
  output logic             reply_ack,
  output logic             mem_read,
  output logic             mem_atomic,
  output logic             mem_wthru,
  output logic             mem_wback,
  output logic             merge,
  output logic             fill,
  output logic             inval,
  output logic             probe_ack,
  output logic             peer_done,
  output logic             retry,
  output logic             touch,
  output logic             trk_alloc,
  output logic             trk_free,
  output logic             ev_illegal
);
  localparam logic [2:0] S_I = 3'd0, S_V = 3'd1, S_M = 3'd2, S_W = 3'd3,
                         S_IV = 3'd4, S_WI = 3'd5, S_A = 3'd6;
  localparam logic [2:0] E_RD = 3'd0, E_WR = 3'd1, E_AT = 3'd2, E_DATA = 3'd3,
                         E_WBACK = 3'd4, E_PROBE = 3'd5, E_REPL = 3'd6;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [2:0]       st, nxt;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             busy;

  assign busy       = (st == S_IV) || (st == S_WI) || (st == S_A);
  assign line_state = st;
  assign atom_pend  = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_I;
      cnt <= '0;
    end else begin
      st  <= nxt;
      cnt <= cnt_n;
    end
  end

  always_comb begin
    nxt = st;  cnt_n = cnt;
    reply_data = 1'b0; reply_ack = 1'b0; mem_read = 1'b0; mem_atomic = 1'b0;
    mem_wthru = 1'b0; mem_wback = 1'b0; merge = 1'b0; fill = 1'b0;
    inval = 1'b0; probe_ack = 1'b0; peer_done = 1'b0; retry = 1'b0;
    touch = 1'b0; trk_alloc = 1'b0; trk_free = 1'b0; ev_illegal = 1'b0;
    if (ev_valid) begin
      case (ev_type)
        E_RD: case (st)
          S_M, S_V: begin reply_data = 1'b1; touch = 1'b1; end
          S_I:  begin trk_alloc = 1'b1; mem_read = 1'b1; nxt = S_IV; end
          S_IV: ;
          S_W:  begin trk_alloc = 1'b1; mem_wback = 1'b1; retry = 1'b1; nxt = S_WI; end
          default: retry = 1'b1;
        endcase
        E_WR: begin
          if (busy) retry = 1'b1;
          else if (wb_mode) begin
            merge = 1'b1; touch = 1'b1; reply_ack = 1'b1;
            nxt = (st == S_I || st == S_W) ? S_W : S_M;
          end else case (st)
            S_I: mem_wthru = 1'b1;
            S_V: begin merge = 1'b1; touch = 1'b1; mem_wthru = 1'b1; end
            default: ev_illegal = 1'b1;
          endcase
        end
        E_AT: case (st)
          S_I, S_V: begin
            inval = 1'b1; trk_alloc = 1'b1; mem_atomic = 1'b1;
            nxt = S_A; cnt_n = CNT_ONE;
          end
          S_A: begin
            if (cnt == CNT_MAX) retry = 1'b1;
            else begin mem_atomic = 1'b1; cnt_n = cnt + CNT_ONE; end
          end
          S_M, S_W: begin trk_alloc = 1'b1; mem_wback = 1'b1; retry = 1'b1; nxt = S_WI; end
          default: retry = 1'b1;
        endcase
        E_DATA: case (st)
          S_IV: begin
            fill = 1'b1; touch = 1'b1; reply_data = 1'b1;
            peer_done = 1'b1; trk_free = 1'b1; nxt = S_V;
          end
          S_A: begin
            reply_data = 1'b1; peer_done = 1'b1; cnt_n = cnt - CNT_ONE;
            if (cnt == CNT_ONE) begin trk_free = 1'b1; nxt = S_I; end
          end
          default: ev_illegal = 1'b1;
        endcase
        E_WBACK: case (st)
          S_WI: begin peer_done = 1'b1; trk_free = 1'b1; nxt = S_I; end
          S_I, S_V, S_IV, S_A: begin reply_ack = 1'b1; peer_done = 1'b1; end
          default: ev_illegal = 1'b1;
        endcase
        E_PROBE: begin
          probe_ack = 1'b1;
          if (st == S_I || st == S_V) nxt = S_I;
          else if (st == S_M) nxt = S_W;
        end
        E_REPL: begin
          inval = 1'b1;
          if (st == S_M || st == S_W) begin
            mem_wback = 1'b1; trk_alloc = 1'b1; nxt = S_WI;
          end else if (st == S_V) nxt = S_I;
        end
        default: ev_illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/l2_line_fsm_chk.sv
module l2_line_fsm_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       line_state,
  input logic [CNT_W-1:0] atom_pend,
  input logic             retry,
  input logic             mem_wback,
  input logic             mem_wthru,
  input logic             probe_ack,
  input logic             ev_illegal,
  input logic             trk_alloc,
  input logic             reply_data,
  input logic             reply_ack
);
  localparam logic [2:0] C_I = 3'd0, C_M = 3'd2, C_W = 3'd3,
                         C_IV = 3'd4, C_WI = 3'd5, C_A = 3'd6;

  AST_WTHRU_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wthru && line_state == C_I) |=> line_state == C_I); // R4

  AST_RETRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (retry && !mem_wback) |=> ($stable(line_state) && $stable(atom_pend))); // R7

  AST_PROBE_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_ack && line_state == C_M) |=> line_state == C_W); // R6

  AST_WBACK_TO_WI: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wback |=> line_state == C_WI); // R12

  AST_TRK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    trk_alloc |=> (line_state == C_IV || line_state == C_WI || line_state == C_A)); // R9

  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_illegal |=> $stable(line_state)); // R13

  AST_PEND_IN_A: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == C_A) == (atom_pend != '0)); // R10

  AST_ONE_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reply_data && reply_ack)); // R11
endmodule

bind l2_line_fsm l2_line_fsm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_state(line_state), .atom_pend(atom_pend),
  .retry(retry), .mem_wback(mem_wback), .mem_wthru(mem_wthru),
  .probe_ack(probe_ack), .ev_illegal(ev_illegal), .trk_alloc(trk_alloc),
  .reply_data(reply_data), .reply_ack(reply_ack)
);

// File: tb/l2_line_fsm_test.sv
`timescale 1ns/1ps
module l2_line_fsm_test;
  localparam int CNT_W = 4;
  localparam logic [15:0] A_RD = 16'h0001, A_RA = 16'h0002, A_MR = 16'h0004, A_MA = 16'h0008,
                          A_WT = 16'h0010, A_WB = 16'h0020, A_MG = 16'h0040, A_FL = 16'h0080,
                          A_IN = 16'h0100, A_PA = 16'h0200, A_PD = 16'h0400, A_RT = 16'h0800,
                          A_TC = 16'h1000, A_TA = 16'h2000, A_TF = 16'h4000, A_IL = 16'h8000;

  logic clk = 1'b0, rst_n = 1'b0, wb_mode = 1'b0, ev_valid = 1'b0;
  logic [2:0] ev_type = 3'd0;
  logic [2:0] line_state;
  logic [CNT_W-1:0] atom_pend;
  logic reply_data, reply_ack, mem_read, mem_atomic, mem_wthru, mem_wback, merge, fill;
  logic inval, probe_ack, peer_done, retry, touch, trk_alloc, trk_free, ev_illegal;
  logic [15:0] acts;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  l2_line_fsm #(.CNT_W(CNT_W)) uut (.*);

  assign acts = {ev_illegal, trk_free, trk_alloc, touch, retry, peer_done, probe_ack, inval,
                 fill, merge, mem_wback, mem_wthru, mem_atomic, mem_read, reply_ack, reply_data};

  // sequential script from reset: {wb, event, expected state, expected strobes}
  localparam logic [22:0] VEC [16] = '{
    {1'b0, 3'd0, 3'd4, A_TA | A_MR},
    {1'b0, 3'd1, 3'd4, A_RT},
    {1'b0, 3'd0, 3'd4, 16'h0000},
    {1'b0, 3'd3, 3'd1, A_FL | A_TC | A_RD | A_PD | A_TF},
    {1'b0, 3'd1, 3'd1, A_MG | A_TC | A_WT},
    {1'b0, 3'd5, 3'd0, A_PA},
    {1'b0, 3'd1, 3'd0, A_WT},
    {1'b1, 3'd1, 3'd3, A_MG | A_TC | A_RA},
    {1'b1, 3'd5, 3'd3, A_PA},
    {1'b1, 3'd0, 3'd5, A_TA | A_WB | A_RT},
    {1'b1, 3'd0, 3'd5, A_RT},
    {1'b1, 3'd4, 3'd0, A_PD | A_TF},
    {1'b1, 3'd2, 3'd6, A_IN | A_TA | A_MA},
    {1'b1, 3'd4, 3'd6, A_RA | A_PD},
    {1'b1, 3'd3, 3'd0, A_RD | A_PD | A_TF},
    {1'b0, 3'd7, 3'd0, A_IL}
  };

  function automatic logic [18:0] ref_step(input logic [2:0] s, input logic [2:0] e, input logic wb);
    logic [2:0] n;
    logic [15:0] a;
    logic bsy;
    n = s; a = '0;
    bsy = (s >= 3'd4);
    case (e)
      3'd0: begin
        if (s == 3'd1 || s == 3'd2) a = A_RD | A_TC;
        else if (s == 3'd0) begin a = A_TA | A_MR; n = 3'd4; end
        else if (s == 3'd3) begin a = A_TA | A_WB | A_RT; n = 3'd5; end
        else if (s != 3'd4) a = A_RT;
      end
      3'd1: begin
        if (bsy) a = A_RT;
        else if (wb) begin a = A_MG | A_TC | A_RA; n = (s == 3'd0 || s == 3'd3) ? 3'd3 : 3'd2; end
        else if (s == 3'd0) a = A_WT;
        else if (s == 3'd1) a = A_MG | A_TC | A_WT;
        else a = A_IL;
      end
      3'd2: begin
        if (s <= 3'd1) begin a = A_IN | A_TA | A_MA; n = 3'd6; end
        else if (s == 3'd6) a = A_MA;
        else if (s <= 3'd3) begin a = A_TA | A_WB | A_RT; n = 3'd5; end
        else a = A_RT;
      end
      3'd3: begin
        if (s == 3'd4) begin a = A_FL | A_TC | A_RD | A_PD | A_TF; n = 3'd1; end
        else if (s == 3'd6) begin a = A_RD | A_PD | A_TF; n = 3'd0; end
        else a = A_IL;
      end
      3'd4: begin
        if (s == 3'd5) begin a = A_PD | A_TF; n = 3'd0; end
        else if (s == 3'd2 || s == 3'd3) a = A_IL;
        else a = A_RA | A_PD;
      end
      3'd5: begin
        a = A_PA;
        if (s <= 3'd1) n = 3'd0; else if (s == 3'd2) n = 3'd3;
      end
      3'd6: begin
        a = A_IN;
        if (s == 3'd2 || s == 3'd3) begin a = A_IN | A_WB | A_TA; n = 3'd5; end
        else if (s <= 3'd1) n = 3'd0;
      end
      default: a = A_IL;
    endcase
    return {n, a};
  endfunction

  function automatic string ev_tag(input logic [2:0] e);
    case (e)
      3'd0: return "R2 R3 R7";
      3'd1: return "R4 R5 R7";
      3'd2: return "R9 R7";
      3'd3: return "R8 R10 R13";
      3'd4: return "R11";
      3'd5: return "R6";
      3'd6: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    ev_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic apply(input logic wb, input logic [2:0] e, output logic [15:0] a, output logic [2:0] s);
    @(negedge clk);
    wb_mode = wb; ev_type = e; ev_valid = 1'b1;
    #1 a = acts;
    @(posedge clk);
    #1 s = line_state; ev_valid = 1'b0;
  endtask

  task automatic step(input logic wb, input logic [2:0] e);
    logic [15:0] a;
    logic [2:0] s;
    apply(wb, e, a, s);
  endtask

  task automatic goto(input logic [2:0] s);
    do_reset();
    case (s)
      3'd1: begin step(0, 0); step(0, 3); end
      3'd2: begin step(0, 0); step(0, 3); step(1, 1); end
      3'd3: step(1, 1);
      3'd4: step(0, 0);
      3'd5: begin step(1, 1); step(1, 6); end
      3'd6: step(0, 2);
      default: ;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] a;
    logic [2:0] s;
    logic [18:0] r;
    do_reset();
    @(negedge clk);
    check("R1 state", 32'(line_state), 32'd0);
    check("R1 count", 32'(atom_pend), 32'd0);
    check("R14 idle strobes", 32'(acts), 32'd0);
    wb_mode = 1'b1; ev_type = 3'd1;
    #1 check("R14 valid low", 32'(acts), 32'd0);
    @(posedge clk); #1 check("R14 state holds", 32'(line_state), 32'd0);

    for (int i = 0; i < 16; i++) begin
      apply(VEC[i][22], VEC[i][21:19], a, s);
      check({"script ", ev_tag(VEC[i][21:19])}, 32'(a), 32'(VEC[i][15:0]));
      check({"script state ", ev_tag(VEC[i][21:19])}, 32'(s), 32'(VEC[i][18:16]));
    end

    for (int m = 0; m < 2; m++)
      for (int st = 0; st < 7; st++)
        for (int e = 0; e < 8; e++) begin
          goto(3'(st));
          apply(1'(m), 3'(e), a, s);
          r = ref_step(3'(st), 3'(e), 1'(m));
          check({"sweep ", ev_tag(3'(e))}, 32'(a), 32'(r[15:0]));
          check({"sweep state ", ev_tag(3'(e))}, 32'(s), 32'(r[18:16]));
        end

    goto(3'd0);
    step(0, 2);
    for (int k = 0; k < 14; k++) step(0, 2);
    @(negedge clk); check("R9 count at max", 32'(atom_pend), 32'd15);
    apply(0, 2, a, s);
    check("R9 saturated retry", 32'(a), 32'(A_RT));
    check("R9 count held", 32'(atom_pend), 32'd15);
    for (int k = 0; k < 14; k++) step(0, 3);
    @(negedge clk); check("R10 count one", 32'(atom_pend), 32'd1);
    check("R10 still A", 32'(line_state), 32'd6);
    apply(0, 3, a, s);
    check("R10 last data", 32'(a), 32'(A_RD | A_PD | A_TF));
    check("R10 back to I", 32'(s), 32'd0);
    check("R10 count cleared", 32'(atom_pend), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule